// File: doc/BRIEF.md
# Split-Word Accumulator Sequencer

This block is a small accumulator machine built around a fetch-execute loop. Each memory word is 40 bits wide and holds two 20-bit instructions. The sequencer fetches one word, runs the lower (left) instruction, and then runs the upper (right) instruction from a holding register. The same word is not fetched a second time. The program counter moves on to the next word only after both halves have run. Arithmetic results go to the accumulator. A second register keeps the high word of the double-length add or subtract result, and a store can write that register back to memory.

The block drives one synchronous single-port memory. The memory takes an address, read data, write data and a write strobe. It returns the addressed word on the clock edge that follows the cycle in which the address was presented. The memory port has a fixed latency and has no valid/ready handshake. The sequencer never waits on the memory, and the memory cannot apply back-pressure. Every access is its own state of the sequencer, which gives the one-cycle read latency room. When the sequencer stops, it raises `halt` and keeps it high until reset.

Top module: `acc_ctrl`

## Requirements
- R1: While `rst` is high and right after it falls, `halt` is low and `mem_we` is low. PC, the accumulator and the high-word register are all zero, and the first fetch reads word 0.
- R2: A word holds the left instruction in bits 19:0, with the opcode in bits 7:0 and the operand address in bits 19:8. It holds the right instruction in bits 39:20, with the opcode in bits 27:20 and the address in bits 39:28. The left instruction always runs before the right one.
- R3: The right instruction runs from the holding register with no second read of its word. The PC advances by one only after both halves have run.
- R4: Opcode 0x01 loads the addressed memory word into the accumulator. The accumulator changes only when a load, add or subtract completes.
- R5: Opcode 0x02 writes the accumulator to the addressed word. Opcode 0x09 writes the high-word register to the addressed word.
- R6: Opcode 0x03 (add) and opcode 0x04 (subtract) form a 41-bit signed result from the accumulator and the memory operand. The accumulator keeps bits 39:0 of that result. The high-word register receives 40 copies of bit 40, so it is always all-zeros or all-ones.
- R7: Opcode 0x05 jumps to the left half of the target word, and opcode 0x06 jumps to its right half. A taken jump discards any right instruction waiting in the holding register. A jump to the right half does not run the left half of the target word.
- R8: Opcode 0x07 jumps to the left half of the target word, and opcode 0x08 jumps to its right half, only when accumulator bit 39 is 0. When bit 39 is 1, execution falls through to the next instruction.
- R9: Opcode 0x00, and every opcode not listed above, stops the machine. `halt` then stays high until reset, and no further memory write occurs.
- R10: Each write is a single-cycle `mem_we` pulse, with the target word on `mem_addr` and the data on `mem_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 12 | Word address for the read or write |
| mem_rdata | input | 40 | Word returned one cycle after its address |
| mem_wdata | output | 40 | Data written when `mem_we` is high |
| mem_we | output | 1 | Write strobe |
| halt | output | 1 | Machine has stopped; held until reset |

## Verification
The assertions assume a memory that returns the word at the presented address exactly one cycle later. They also assume that `rst` is synchronous and that the memory contents change only through the block's own writes while the block runs. The bench model uses a registered read and loads programs only while reset is held, so every property sees a memory the sequencer fully controls. The programs contain some words that change themselves, and these are written so that a re-fetch of the current word would give a visibly different result.

// File: rtl/acc_pkg.sv
package acc_pkg;

  localparam logic [7:0] OPC_HALT  = 8'h00;
  localparam logic [7:0] OPC_LOAD  = 8'h01;
  localparam logic [7:0] OPC_STORE = 8'h02;
  localparam logic [7:0] OPC_ADD   = 8'h03;
  localparam logic [7:0] OPC_SUB   = 8'h04;
  localparam logic [7:0] OPC_JMPL  = 8'h05;
  localparam logic [7:0] OPC_JMPR  = 8'h06;
  localparam logic [7:0] OPC_JGEL  = 8'h07;
  localparam logic [7:0] OPC_JGER  = 8'h08;
  localparam logic [7:0] OPC_STHI  = 8'h09;

  typedef enum logic [3:0] {
    S_FMAR, S_FRD, S_FMBR, S_FSPLIT,
    S_DEC, S_ERD, S_EMBR, S_EXE, S_EWR,
    S_NEXT, S_HALT
  } seq_state_t;

  typedef enum logic [2:0] {
    K_LOAD, K_STORE, K_STHI, K_ADD, K_SUB, K_JMP, K_JGE, K_STOP
  } op_kind_t;

endpackage

// File: rtl/acc_decode.sv
module acc_decode
  import acc_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic [OP_W-1:0] op,
  output op_kind_t        kind,
  output logic            to_right
);

  always_comb begin
    to_right = 1'b0;
    case (op)
      OP_W'(OPC_LOAD):  kind = K_LOAD;
      OP_W'(OPC_STORE): kind = K_STORE;
      OP_W'(OPC_STHI):  kind = K_STHI;
      OP_W'(OPC_ADD):   kind = K_ADD;
      OP_W'(OPC_SUB):   kind = K_SUB;
      OP_W'(OPC_JMPL):  kind = K_JMP;
      OP_W'(OPC_JMPR): begin
        kind     = K_JMP;
        to_right = 1'b1;
      end
      OP_W'(OPC_JGEL):  kind = K_JGE;
      OP_W'(OPC_JGER): begin
        kind     = K_JGE;
        to_right = 1'b1;
      end
      default:          kind = K_STOP;
    endcase
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int WORD_W = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exe_en,
  input  op_kind_t          kind,
  input  logic [WORD_W-1:0] operand,
  output logic [WORD_W-1:0] ac,
  output logic [WORD_W-1:0] mq
);

  logic [WORD_W:0] wide;

  always_comb begin
    case (kind)
      K_ADD:   wide = {ac[WORD_W-1], ac} + {operand[WORD_W-1], operand};
      K_SUB:   wide = {ac[WORD_W-1], ac} - {operand[WORD_W-1], operand};
      default: wide = {operand[WORD_W-1], operand};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ac <= '0;
      mq <= '0;
    end else if (exe_en) begin
      if (kind == K_LOAD) begin
        ac <= operand;
      end else if (kind == K_ADD || kind == K_SUB) begin
        ac <= wide[WORD_W-1:0];
        mq <= {WORD_W{wide[WORD_W]}};
      end
    end
  end

  AST_HIGH_WORD_SIGN: assert property (@(posedge clk) disable iff (rst)
    (mq == '0) || (mq == '1)); // R6

  AST_AC_ONLY_ON_EXEC: assert property (@(posedge clk) disable iff (rst)
    !exe_en |=> $stable(ac)); // R4

endmodule

// File: rtl/acc_seq.sv
module acc_seq
  import acc_pkg::*;
#(
  parameter int OP_W   = 8,
  parameter int ADDR_W = 12,
  localparam int HALF_W = OP_W + ADDR_W,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] mem_rdata,
  input  op_kind_t          kind,
  input  logic              to_right,
  input  logic              ac_neg,
  output logic [OP_W-1:0]   ir_op,
  output logic [WORD_W-1:0] mbr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic              exe_en,
  output logic              halt
);

  seq_state_t        st;
  logic [ADDR_W-1:0] pc;
  logic [ADDR_W-1:0] mar;
  logic [HALF_W-1:0] ir;
  logic [HALF_W-1:0] ibr;
  logic              ibr_pend;
  logic              tgt_right;
  logic [ADDR_W-1:0] ir_addr;

  assign ir_op    = ir[OP_W-1:0];
  assign ir_addr  = ir[HALF_W-1:OP_W];
  assign mem_addr = mar;
  assign mem_we   = (st == S_EWR);
  assign exe_en   = (st == S_EXE);
  assign halt     = (st == S_HALT);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_FMAR;
      pc        <= '0;
      mar       <= '0;
      mbr       <= '0;
      ir        <= '0;
      ibr       <= '0;
      ibr_pend  <= 1'b0;
      tgt_right <= 1'b0;
    end else begin
      case (st)
        S_FMAR: begin
          mar <= pc;
          st  <= S_FRD;
        end
        S_FRD:  st <= S_FMBR;
        S_FMBR: begin
          mbr <= mem_rdata;
          st  <= S_FSPLIT;
        end
        S_FSPLIT: begin
          if (tgt_right) begin
            ir       <= mbr[WORD_W-1:HALF_W];
            ibr_pend <= 1'b0;
          end else begin
            ir       <= mbr[HALF_W-1:0];
            ibr      <= mbr[WORD_W-1:HALF_W];
            ibr_pend <= 1'b1;
          end
          tgt_right <= 1'b0;
          st        <= S_DEC;
        end
        S_DEC: begin
          case (kind)
            K_STOP: st <= S_HALT;
            K_JMP, K_JGE: begin
              if (kind == K_JMP || !ac_neg) begin
                pc        <= ir_addr;
                tgt_right <= to_right;
                ibr_pend  <= 1'b0;
                st        <= S_FMAR;
              end else begin
                st <= S_NEXT;
              end
            end
            K_STORE, K_STHI: begin
              mar <= ir_addr;
              st  <= S_EWR;
            end
            default: begin
              mar <= ir_addr;
              st  <= S_ERD;
            end
          endcase
        end
        S_ERD:  st <= S_EMBR;
        S_EMBR: begin
          mbr <= mem_rdata;
          st  <= S_EXE;
        end
        S_EXE:  st <= S_NEXT;
        S_EWR:  st <= S_NEXT;
        S_NEXT: begin
          if (ibr_pend) begin
            ir       <= ibr;
            ibr_pend <= 1'b0;
            st       <= S_DEC;
          end else begin
            pc <= pc + 1'b1;
            st <= S_FMAR;
          end
        end
        S_HALT:  st <= S_HALT;
        default: st <= S_HALT;
      endcase
    end
  end

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    halt |=> halt); // R9

  AST_NO_WRITE_HALTED: assert property (@(posedge clk) disable iff (rst)
    halt |-> !mem_we); // R9

  AST_WRITE_PULSE: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we); // R10

  AST_PC_HELD_FOR_RIGHT: assert property (@(posedge clk) disable iff (rst)
    (st == S_NEXT && ibr_pend) |=> $stable(pc)); // R3

  AST_FETCH_FROM_PC: assert property (@(posedge clk) disable iff (rst)
    (st == S_FRD) |-> (mem_addr == pc)); // R3

endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_pkg::*;
#(
  parameter int OP_W   = 8,
  parameter int ADDR_W = 12,
  localparam int HALF_W = OP_W + ADDR_W,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              halt
);

  op_kind_t          kind;
  logic              to_right;
  logic [OP_W-1:0]   ir_op;
  logic [WORD_W-1:0] mbr;
  logic [WORD_W-1:0] ac;
  logic [WORD_W-1:0] mq;
  logic              exe_en;

  acc_decode #(.OP_W(OP_W)) u_dec (
    .op       (ir_op),
    .kind     (kind),
    .to_right (to_right)
  );

  acc_seq #(.OP_W(OP_W), .ADDR_W(ADDR_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .mem_rdata (mem_rdata),
    .kind      (kind),
    .to_right  (to_right),
    .ac_neg    (ac[WORD_W-1]),
    .ir_op     (ir_op),
    .mbr       (mbr),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .exe_en    (exe_en),
    .halt      (halt)
  );

  acc_alu #(.WORD_W(WORD_W)) u_alu (
    .clk     (clk),
    .rst     (rst),
    .exe_en  (exe_en),
    .kind    (kind),
    .operand (mbr),
    .ac      (ac),
    .mq      (mq)
  );

  assign mem_wdata = (kind == K_STHI) ? mq : ac;

endmodule

// File: tb/test_acc_ctrl.sv
`timescale 1ns/1ps
module test_acc_ctrl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] mem_addr;
  logic [39:0] mem_rdata;
  logic [39:0] mem_wdata;
  logic        mem_we;
  logic        halt;

  logic [39:0] mem [0:255];
  logic        ld_en = 1'b0;
  logic        ld_clr = 1'b0;
  logic [7:0]  ld_addr = '0;
  logic [39:0] ld_data = '0;

  int nchk = 0;
  int nerr = 0;
  int pulse_err = 0;
  int halted_wr = 0;
  logic prev_we = 1'b0;

  always #10 clk = ~clk;

  acc_ctrl i_acc_ctrl (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .halt      (halt)
  );

  always @(posedge clk) begin
    if (ld_clr) begin
      for (int i = 0; i < 256; i++) mem[i] <= '0;
    end else if (ld_en) begin
      mem[ld_addr] <= ld_data;
    end else if (mem_we) begin
      mem[mem_addr[7:0]] <= mem_wdata;
    end
    mem_rdata <= mem[mem_addr[7:0]];
  end

  always @(posedge clk) begin
    if (!rst) begin
      if (mem_we && prev_we) pulse_err++;
      if (halt && mem_we) halted_wr++;
      prev_we <= mem_we;
    end else begin
      prev_we <= 1'b0;
    end
  end

  function automatic logic [39:0] mkw(logic [7:0] lop, logic [11:0] la,
                                      logic [7:0] rop, logic [11:0] ra);
    return {ra, rop, la, lop};
  endfunction

  task automatic check(string req, logic [39:0] act, logic [39:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic poke(int a, logic [39:0] d);
    @(negedge clk);
    ld_en = 1'b1;
    ld_addr = 8'(a);
    ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic start_prog();
    @(negedge clk);
    rst = 1'b1;
    ld_clr = 1'b1;
    @(negedge clk);
    ld_clr = 1'b0;
  endtask

  task automatic run_prog(string req);
    int n;
    n = 0;
    @(negedge clk);
    rst = 1'b0;
    while (!halt && n < 3000) begin
      @(negedge clk);
      n++;
    end
    check({req, " reached halt"}, {39'd0, halt}, 40'd1);
  endtask

  // a, b, subtract flag
  localparam logic [80:0] VEC [6] = '{
    {40'd5,           40'd7,           1'b0},
    {40'h7FFFFFFFFF,  40'd1,           1'b0},
    {40'hFFFFFFFFFB,  40'd2,           1'b0},
    {40'd3,           40'd10,          1'b1},
    {40'h8000000000,  40'd1,           1'b1},
    {40'd100,         40'd100,         1'b1}
  };

  initial begin
    #(200000 * 20);
    nerr++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    // R1: reset state
    start_prog();
    @(negedge clk);
    check("R1 halt in reset", {39'd0, halt}, 40'd0);
    check("R1 we in reset", {39'd0, mem_we}, 40'd0);
    check("R1 addr in reset", {28'd0, mem_addr}, 40'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 first fetch word 0", {28'd0, mem_addr}, 40'd0);
    check("R1 halt after reset", {39'd0, halt}, 40'd0);

    // R2 R4 R5 R6: vector table
    for (int v = 0; v < 6; v++) begin
      logic [39:0] a, b;
      logic        sb;
      logic [40:0] r;
      {a, b, sb} = VEC[v];
      r = sb ? ({a[39], a} - {b[39], b}) : ({a[39], a} + {b[39], b});
      start_prog();
      poke(0, mkw(8'h01, 12'd100, sb ? 8'h04 : 8'h03, 12'd101));
      poke(1, mkw(8'h02, 12'd102, 8'h09, 12'd103));
      poke(2, 40'd0);
      poke(100, a);
      poke(101, b);
      poke(103, 40'h123);
      run_prog("R6");
      check("R6 accumulator result", mem[102], r[39:0]);
      check("R5 high word store", mem[103], {40{r[40]}});
      check("R4 operand kept", mem[100], a);
    end

    // R3: left half overwrites its own word; right half must still run from buffer
    start_prog();
    poke(0, mkw(8'h01, 12'd100, 8'h03, 12'd101));
    poke(1, mkw(8'h02, 12'd1, 8'h02, 12'd102));
    poke(2, 40'd0);
    poke(100, 40'h10);
    poke(101, 40'h20);
    run_prog("R3");
    check("R3 self-overwrite", mem[1], 40'h30);
    check("R3 right half from buffer", mem[102], 40'h30);

    // R7: jump left discards buffered right half
    start_prog();
    poke(0, mkw(8'h05, 12'd4, 8'h02, 12'd110));
    poke(4, mkw(8'h01, 12'd100, 8'h02, 12'd111));
    poke(5, 40'd0);
    poke(100, 40'd77);
    poke(110, 40'hAAA);
    run_prog("R7");
    check("R7 buffered half discarded", mem[110], 40'hAAA);
    check("R7 target executed", mem[111], 40'd77);

    // R7: jump right skips left half of target
    start_prog();
    poke(0, mkw(8'h01, 12'd100, 8'h06, 12'd6));
    poke(6, mkw(8'h02, 12'd113, 8'h02, 12'd111));
    poke(7, 40'd0);
    poke(100, 40'd55);
    poke(113, 40'hBBB);
    run_prog("R7");
    check("R7 left of target skipped", mem[113], 40'hBBB);
    check("R7 right of target ran", mem[111], 40'd55);

    // R8: conditional jump, negative then non-negative accumulator
    for (int k = 0; k < 2; k++) begin
      logic [39:0] val;
      val = (k == 0) ? 40'hF000000001 : 40'd9;
      start_prog();
      poke(0, mkw(8'h01, 12'd100, 8'h07, 12'd4));
      poke(1, mkw(8'h02, 12'd111, 8'h00, 12'd0));
      poke(4, mkw(8'h02, 12'd112, 8'h00, 12'd0));
      poke(100, val);
      poke(111, 40'hCCC);
      poke(112, 40'hCCC);
      run_prog("R8");
      check("R8 fall-through path", mem[111], (k == 0) ? val : 40'hCCC);
      check("R8 taken path", mem[112], (k == 0) ? 40'hCCC : val);
    end

    // R9: unlisted opcode halts, halt sticky, no writes afterwards
    start_prog();
    poke(0, mkw(8'hEE, 12'd0, 8'h02, 12'd111));
    poke(111, 40'hDDD);
    run_prog("R9");
    repeat (30) @(negedge clk);
    check("R9 halt held", {39'd0, halt}, 40'd1);
    check("R9 right half not run", mem[111], 40'hDDD);
    check("R9 no write while halted", 40'(halted_wr), 40'd0);

    // R10: single-cycle write pulses over whole run
    check("R10 write pulse width", 40'(pulse_err), 40'd0);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule